// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a one-shot supervision timer controlled by one 8-bit configuration register. The register holds three fields. A 2-bit resolution code picks the length of one counting unit from a slow base tick. A 5-bit multiplier says how many units must pass. A steering bit chooses where the timeout goes. Software restarts the timer by writing the register again. If it fails to do so in time, the block sets a sticky timeout flag and raises either an interrupt pulse or a reset pulse.

The base tick is a single-clock strobe at 16 Hz, made outside the block. A read strobe returns the flag register and clears the timeout flag. After a timeout the block stays idle until the configuration register is written again. A multiplier of zero keeps it idle.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset, both pulse outputs are low, a flag read returns 0x00 and the timer is idle.
- R2: Configuration bits [1:0] set the unit length in base ticks: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64.
- R3: Configuration bits [6:2] are the multiplier M. The timeout occurs on the (M × unit)-th base tick counted from the write.
- R4: When M = 0 the timer never times out.
- R5: Any write reloads the count from the new value and restarts the unit prescaler, so an earlier partial count is discarded.
- R6: Configuration bit 7 picks the output. 0 pulses `wd_irq`, 1 pulses `wd_reset`, and the other output stays low.
- R7: The pulse rises in the cycle after the expiring tick. It falls in the cycle after the next base tick, so it lasts exactly one base-tick period.
- R8: After one timeout the timer is idle until the next write. There is no second pulse.
- R9: A timeout sets flag bit 7. A read strobe loads `flag_rdata` in the next cycle with the flag value from before the read and clears the flag. A timeout in the same cycle as a read leaves the flag set.
- R10: A base tick in the same cycle as a write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16hz | input | 1 | One-cycle strobe at the 16 Hz base rate |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | {steer, multiplier[4:0], resolution[1:0]} |
| flag_re | input | 1 | Flag register read strobe (clears the timeout flag) |
| flag_rdata | output | 8 | Flag value captured at the last read; bit 7 is the timeout flag |
| wd_irq | output | 1 | Timeout pulse when steer = 0 |
| wd_reset | output | 1 | Timeout pulse when steer = 1 |

## Verification
A wrong prescaler phase or remaining count shows up as a pulse that starts one or more base ticks early or late. The error is visible at the latest when the full timeout elapses, which can take up to 1984 base ticks with the largest settings. A wrong armed state shows as a pulse that is missing or comes twice. A wrong flag state shows on the next read strobe, one cycle later. Because the bench compares the pulse outputs and `flag_rdata` with a reference on every clock, each of these errors is reported in the first cycle it reaches a port.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    RES_SIXTEENTH = 2'b00,
    RES_QUARTER   = 2'b01,
    RES_ONE       = 2'b10,
    RES_FOUR      = 2'b11
  } wdt_res_e;

  // width of the prescaler needed to cover the coarsest resolution
  function automatic int pre_width(input int res_w);
    return 2 * ((1 << res_w) - 1);
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int RES_W = 2,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [RES_W-1:0] res,
  output logic             unit
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  // each resolution step multiplies the unit by four: two more low bits must be all ones
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < 2 * int'(res));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign unit = tick && !restart && ((cnt_q & mask) == mask);

  AST_NO_UNIT_ON_KICK: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int MULT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MULT_W-1:0] load_val,
  input  logic              unit,
  output logic              armed,
  output logic              expire
);
  logic [MULT_W-1:0] rem_q;
  logic              armed_q;

  assign expire = unit && armed_q && (rem_q == MULT_W'(1));
  assign armed  = armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      rem_q   <= load_val;
      armed_q <= (load_val != '0);
    end else if (unit && armed_q) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == MULT_W'(1)) begin
        armed_q <= 1'b0;
      end
    end
  end

  AST_ARMED_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (rem_q != '0)); // R3
  AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> !armed_q); // R4
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> !armed_q); // R8
endmodule

// File: rtl/wdt_flags_out.sv
module wdt_flags_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              expire,
  input  logic              steer,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_out
);
  logic wdf_q;
  logic irq_q;
  logic rso_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wdf_q   <= 1'b0;
      irq_q   <= 1'b0;
      rso_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (tick) begin
        irq_q <= expire && !steer;
        rso_q <= expire && steer;
      end
      if (rd) begin
        rdata_q <= {wdf_q, {(DATA_W-1){1'b0}}};
      end
      if (expire) begin
        wdf_q <= 1'b1;
      end else if (rd) begin
        wdf_q <= 1'b0;
      end
    end
  end

  assign rdata   = rdata_q;
  assign irq     = irq_q;
  assign rst_out = rso_q;

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !(irq_q && rso_q)); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    expire |=> wdf_q); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !tick) |=> irq_q); // R7
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rso_q && !tick) |=> rso_q); // R7
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_q) || $rose(rso_q)) |-> $past(expire)); // R7
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_16hz,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       flag_re,
  output logic [7:0] flag_rdata,
  output logic       wd_irq,
  output logic       wd_reset
);
  localparam int DATA_W   = MULT_W + RES_W + 1;
  localparam int PRE_W    = pre_width(RES_W);
  localparam int MULT_LSB = RES_W;
  localparam int STEER_B  = DATA_W - 1;

  logic [DATA_W-1:0] cfg_q;
  logic              unit;
  logic              armed;
  logic              expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata[DATA_W-1:0];
    end
  end

  // resolution comes from the register after the write; on the write cycle the prescaler is cleared anyway
  wdt_prescaler #(.RES_W(RES_W), .PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (cfg_we),
    .tick    (tick_16hz),
    .res     (cfg_q[RES_W-1:0]),
    .unit    (unit)
  );

  wdt_countdown #(.MULT_W(MULT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_we),
    .load_val (cfg_wdata[MULT_LSB +: MULT_W]),
    .unit     (unit),
    .armed    (armed),
    .expire   (expire)
  );

  wdt_flags_out #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_16hz),
    .expire  (expire),
    .steer   (cfg_q[STEER_B]),
    .rd      (flag_re),
    .rdata   (flag_rdata),
    .irq     (wd_irq),
    .rst_out (wd_reset)
  );

  AST_KICK_BLOCKS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> !expire); // R10
  AST_IDLE_NO_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !expire); // R8
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_16hz = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       flag_re = 1'b0;
  logic [7:0] flag_rdata;
  logic       wd_irq;
  logic       wd_reset;

  int errors = 0;
  int checks = 0;
  string phase = "R1";
  logic tick_en = 1'b0;
  int cyc = 0;
  logic done = 1'b0;

  wdog_timer u0 (
    .clk(clk), .rst(rst), .tick_16hz(tick_16hz), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .flag_re(flag_re), .flag_rdata(flag_rdata),
    .wd_irq(wd_irq), .wd_reset(wd_reset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // base tick generator
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_16hz <= tick_en && ((cyc % TICK_GAP) == 0);
  end

  // reference model: ticks counted since the last write
  int m_cnt = 0, m_target = 0;
  bit m_armed = 0, m_irq = 0, m_rst = 0, m_wdf = 0, m_steer = 0;
  logic [7:0] m_rd = '0;

  always @(posedge clk) begin
    bit ex;
    ex = 0;
    if (rst) begin
      m_cnt = 0; m_target = 0; m_armed = 0; m_irq = 0; m_rst = 0;
      m_wdf = 0; m_steer = 0; m_rd = '0;
    end else begin
      if (cfg_we) begin
        m_cnt = 0;
        m_target = int'(cfg_wdata[6:2]) * (1 << (2 * int'(cfg_wdata[1:0])));
        m_armed = (cfg_wdata[6:2] != 0);
        m_steer = cfg_wdata[7];
      end else if (tick_16hz) begin
        m_cnt++;
        if (m_armed && m_cnt == m_target) begin
          ex = 1;
          m_armed = 0;
        end
      end
      if (tick_16hz) begin
        m_irq = ex && !m_steer;
        m_rst = ex && m_steer;
      end
      if (flag_re) m_rd = {m_wdf, 7'b0};
      if (ex) m_wdf = 1;
      else if (flag_re) m_wdf = 0;
    end
  end

  // pulse monitor
  int pulses = 0, hi_cycles = 0, irq_pulses = 0, rst_pulses = 0;
  bit prev_any = 0;

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (wd_irq !== m_irq || wd_reset !== m_rst || flag_rdata !== m_rd) begin
        errors++;
        $display("FAIL %s cycle %0d: irq/rst/rdata got %b/%b/%h expected %b/%b/%h",
                 phase, cyc, wd_irq, wd_reset, flag_rdata, m_irq, m_rst, m_rd);
      end
      if ((wd_irq || wd_reset) && !prev_any) begin
        pulses++;
        if (wd_irq) irq_pulses++;
        if (wd_reset) rst_pulses++;
      end
      if (wd_irq || wd_reset) hi_cycles++;
      prev_any = wd_irq || wd_reset;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); flag_re = 1'b1;
    @(negedge clk); flag_re = 1'b0;
    v = flag_rdata;
  endtask

  task automatic clear_mon();
    pulses = 0; hi_cycles = 0; irq_pulses = 0; rst_pulses = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    wait_cyc(5);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 irq", int'(wd_irq), 0);
    check("R1 reset out", int'(wd_reset), 0);
    do_read(rv);
    check("R1 flags", int'(rv), 0);
    tick_en = 1'b1;

    // R2 R3 R6 R7: res 00, mult 3, interrupt
    phase = "R3"; clear_mon();
    do_write(8'h0C);
    wait_cyc(3 * TICK_GAP + 12);
    check("R6 irq pulses", irq_pulses, 1);
    check("R6 reset pulses", rst_pulses, 0);
    check("R7 pulse width", hi_cycles, TICK_GAP);
    do_read(rv);
    check("R9 flag set", int'(rv), 8'h80);
    do_read(rv);
    check("R9 flag cleared", int'(rv), 0);

    // R2 R6: res 01, mult 2, reset output
    phase = "R2"; clear_mon();
    do_write(8'h89);
    wait_cyc(8 * TICK_GAP + 12);
    check("R6 reset pulses", rst_pulses, 1);
    check("R6 irq pulses", irq_pulses, 0);
    do_read(rv);
    check("R9 flag after reset pulse", int'(rv), 8'h80);

    // R2: res 10 mult 1, res 11 mult 2
    clear_mon();
    do_write(8'h06);
    wait_cyc(16 * TICK_GAP + 12);
    check("R2 res 10 pulses", pulses, 1);
    clear_mon();
    do_write(8'h0B);
    wait_cyc(128 * TICK_GAP + 12);
    check("R2 res 11 pulses", pulses, 1);

    // R3 largest setting, steer to reset
    phase = "R3"; clear_mon();
    do_write(8'hFF);
    wait_cyc(1984 * TICK_GAP + 12);
    check("R3 max timeout pulses", rst_pulses, 1);
    // R8: no further pulse while idle
    phase = "R8"; clear_mon();
    wait_cyc(300);
    check("R8 no re-expiry", pulses, 0);
    do_read(rv);

    // R4: multiplier zero
    phase = "R4"; clear_mon();
    do_write(8'h03);
    wait_cyc(600);
    check("R4 no pulse", pulses, 0);
    do_read(rv);
    check("R4 flag clear", int'(rv), 0);

    // R5: repeated kicks before timeout
    phase = "R5"; clear_mon();
    for (int k = 0; k < 10; k++) begin
      do_write(8'h10);
      wait_cyc(2 * TICK_GAP);
    end
    check("R5 kicked no pulse", pulses, 0);
    wait_cyc(4 * TICK_GAP + 12);
    check("R5 expiry after last kick", pulses, 1);
    do_read(rv);

    // R10: writes on every cycle including tick cycles
    phase = "R10"; clear_mon();
    @(negedge clk); cfg_wdata = 8'h04; cfg_we = 1'b1;
    wait_cyc(12);
    cfg_we = 1'b0;
    check("R10 no pulse during writes", pulses, 0);
    wait_cyc(TICK_GAP + 10);
    check("R10 single pulse after writes", pulses, 1);
    do_read(rv);

    // R9: reads held across an expiry
    phase = "R9"; clear_mon();
    do_write(8'h0C);
    @(negedge clk); flag_re = 1'b1;
    wait_cyc(40);
    flag_re = 1'b0;
    wait_cyc(2);
    do_read(rv);
    check("R9 flag cleared by reads", int'(rv), 0);

    wait_cyc(5);
    finish_run();
  end
endmodule